// File: doc/BRIEF.md
# VBI Line Timing Generator

This block tracks the line position inside a video field so that a data slicer downstream knows when to act. It counts horizontal sync pulses from the start of each field. A field-start strobe carries a parity bit. From the count the block produces three outputs. The first is a fixed-width marker pulse on line 26, in every field. The second is a level that shows whether the current field is odd or even. The third is a gate pulse on each line that the host has enabled for slicing.

The host writes a 16-bit enable mask. Each bit stands for one line in a run of 16 consecutive lines that starts at a parameterised base line. The sync input may carry equalising pulses at twice the line rate. Any sync edge that comes too soon after the last accepted one is therefore discarded. All widths and spacings are parameters counted in system clock cycles.

Top module: `vbi_line_timer`

## Requirements
- R1: After reset `ln26_out`, `slice_out` and `field_odd_out` are low. Until the first field-start strobe the line position is idle, and sync pulses produce no `ln26_out` or `slice_out` pulse.
- R2: A cycle with `vsync_in` high sets the line position to 1. It copies `field_par_in` to `field_odd_out` (1 = odd field, 0 = even field), which then holds until the next strobe.
- R3: Each accepted rising edge of `hs_in` advances the line position by one. A sync level held high for several cycles counts only once.
- R4: A rising edge of `hs_in` fewer than `MIN_HS_GAP` cycles after the last accepted edge is ignored and does not advance the line.
- R5: The edge that starts line `LN26_LINE` (26) starts an `ln26_out` pulse in the following cycle. The pulse is exactly `LN26_WIDTH` cycles long and appears in odd and even fields alike.
- R6: A cycle with `sel_wr` high loads `sel_data` as the line mask. Bit i enables line `SEL_BASE`+i, for i from 0 to 15. Lines outside that window are never enabled.
- R7: The edge that starts an enabled line starts a `slice_out` pulse in the following cycle. The pulse lasts `SLICE_WIDTH` cycles.
- R8: Any accepted sync edge or field-start strobe ends a running `slice_out` pulse. If the new line is enabled, the pulse restarts with its full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_in | input | 1 | Horizontal sync, active high |
| vsync_in | input | 1 | Field-start strobe |
| field_par_in | input | 1 | Parity of the starting field, sampled with `vsync_in` |
| sel_wr | input | 1 | Load strobe for the line mask |
| sel_data | input | 16 | Line mask value |
| ln26_out | output | 1 | Line-26 marker pulse |
| field_odd_out | output | 1 | High in odd fields, low in even fields |
| slice_out | output | 1 | Gate pulse on enabled lines |

## Verification
The bench sends a sync edge a few cycles after an accepted one, as an equalising pulse would. A block that does not filter such edges gates the wrong line, one line early. It also holds sync high for several cycles. Edge detection that counts levels would then skip lines. It spaces sync edges closer than the gate width, both into an enabled line and into a disabled one. A block that does not cut the pulse short would stretch the gate across a line that is not enabled. A block that does not restart the pulse would end the gate too early. Finally, it runs sync before any field strobe and checks the marker in both parities. This catches pulses fired from an idle count and a marker that is tied to one field.

// File: rtl/vbi_pkg.sv
package vbi_pkg;

    localparam int LINE_W   = 10;
    localparam int SEL_BITS = 16;

    typedef logic [LINE_W-1:0]   line_t;
    typedef logic [SEL_BITS-1:0] sel_mask_t;

    localparam line_t LINE_IDLE = '0;
    localparam line_t LINE_MAX  = '1;

    typedef struct packed {
        line_t line;
        logic  odd;
    } field_state_t;

    typedef struct packed {
        logic start;
        logic clear;
    } pulse_ctl_t;

    function automatic logic line_enabled(line_t l, line_t base, sel_mask_t mask);
        line_t off;
        off = l - base;
        if (l < base || off >= line_t'(SEL_BITS))
            return 1'b0;
        return mask[off[3:0]];
    endfunction

    function automatic line_t line_step(line_t l);
        if (l == LINE_IDLE || l == LINE_MAX)
            return l;
        return l + line_t'(1);
    endfunction

endpackage

// File: rtl/vbi_hs_qual.sv
module vbi_hs_qual #(
    parameter int MIN_GAP = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_in,
    output logic hs_acc
);
    localparam int GW = $clog2(MIN_GAP + 1) + 1;

    logic          hs_d;
    logic [GW-1:0] gap;
    logic          rise;

    assign rise   = hs_in & ~hs_d;
    assign hs_acc = rise && (gap >= GW'(MIN_GAP));

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_d <= 1'b0;
            gap  <= GW'(MIN_GAP);
        end else begin
            hs_d <= hs_in;
            if (hs_acc)
                gap <= GW'(1);
            else if (gap < GW'(MIN_GAP))
                gap <= gap + GW'(1);
        end
    end

    // R4: two accepted edges can never sit in adjacent cycles
    p_gap_reject_r4: assert property (@(posedge clk) disable iff (rst)
        (hs_acc && MIN_GAP > 1) |=> !hs_acc);

endmodule

// File: rtl/vbi_field_track.sv
module vbi_field_track
    import vbi_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         vsync_in,
    input  logic         field_par_in,
    input  logic         hs_acc,
    output field_state_t st
);
    field_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.line <= LINE_IDLE;
            st_q.odd  <= 1'b0;
        end else if (vsync_in) begin
            st_q.line <= line_t'(1);
            st_q.odd  <= field_par_in;
        end else if (hs_acc) begin
            st_q.line <= line_step(st_q.line);
        end
    end

    assign st = st_q;

    p_field_start_r2: assert property (@(posedge clk) disable iff (rst)
        vsync_in |=> (st.line == line_t'(1)) && (st.odd == $past(field_par_in)));

    p_field_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !vsync_in |=> $stable(st.odd));

    p_line_step_r3: assert property (@(posedge clk) disable iff (rst)
        (hs_acc && !vsync_in && st.line != LINE_IDLE && st.line != LINE_MAX)
        |=> st.line == $past(st.line) + line_t'(1));

endmodule

// File: rtl/vbi_pulse_timer.sv
module vbi_pulse_timer
    import vbi_pkg::*;
#(
    parameter int WIDTH = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  pulse_ctl_t ctl,
    output logic       active
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (ctl.start)
            remain <= CW'(WIDTH);
        else if (ctl.clear)
            remain <= '0;
        else if (remain != '0)
            remain <= remain - CW'(1);
    end

    assign active = (remain != '0);

    p_start_on_r7: assert property (@(posedge clk) disable iff (rst)
        ctl.start |=> active);

endmodule

// File: rtl/vbi_line_timer.sv
module vbi_line_timer
    import vbi_pkg::*;
#(
    parameter int LN26_WIDTH  = 515,
    parameter int SLICE_WIDTH = 512,
    parameter int MIN_HS_GAP  = 400,
    parameter int SEL_BASE    = 10,
    parameter int LN26_LINE   = 26
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hs_in,
    input  logic        vsync_in,
    input  logic        field_par_in,
    input  logic        sel_wr,
    input  logic [15:0] sel_data,
    output logic        ln26_out,
    output logic        field_odd_out,
    output logic        slice_out
);
    localparam line_t BASE_L   = line_t'(SEL_BASE);
    localparam line_t MARK_L   = line_t'(LN26_LINE);

    logic         hs_acc;
    field_state_t st;
    sel_mask_t    mask_q;
    line_t        next_line;
    logic         advance;
    pulse_ctl_t   mark_ctl;
    pulse_ctl_t   gate_ctl;

    vbi_hs_qual #(.MIN_GAP(MIN_HS_GAP)) u_qual (
        .clk    (clk),
        .rst    (rst),
        .hs_in  (hs_in),
        .hs_acc (hs_acc)
    );

    vbi_field_track u_track (
        .clk          (clk),
        .rst          (rst),
        .vsync_in     (vsync_in),
        .field_par_in (field_par_in),
        .hs_acc       (hs_acc),
        .st           (st)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (sel_wr)
            mask_q <= sel_data;
    end

    assign next_line = line_step(st.line);
    assign advance   = hs_acc && !vsync_in && (st.line != LINE_IDLE);

    always_comb begin
        mark_ctl.start = advance && (next_line == MARK_L) && (st.line != MARK_L);
        mark_ctl.clear = 1'b0;
        gate_ctl.start = advance && line_enabled(next_line, BASE_L, mask_q)
                         && (next_line != st.line);
        gate_ctl.clear = hs_acc || vsync_in;
    end

    vbi_pulse_timer #(.WIDTH(LN26_WIDTH)) u_mark (
        .clk    (clk),
        .rst    (rst),
        .ctl    (mark_ctl),
        .active (ln26_out)
    );

    vbi_pulse_timer #(.WIDTH(SLICE_WIDTH)) u_gate (
        .clk    (clk),
        .rst    (rst),
        .ctl    (gate_ctl),
        .active (slice_out)
    );

    assign field_odd_out = st.odd;

    p_mark_line_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ln26_out) |-> st.line == MARK_L);

    p_gate_after_hs_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(slice_out) |-> $past(hs_acc));

    p_gate_window_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(slice_out) |-> (st.line >= BASE_L) && (st.line < BASE_L + line_t'(SEL_BITS)));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (st.line == LINE_IDLE) |=> !$rose(slice_out) && !$rose(ln26_out));

    p_cut_on_sync_r8: assert property (@(posedge clk) disable iff (rst)
        (slice_out && vsync_in) |=> !slice_out);

endmodule

// File: tb/tb_vbi_line_timer.sv
module tb_vbi_line_timer;
    localparam int CLK_PERIOD = 10;
    localparam int P   = 40;
    localparam int W26 = 12;
    localparam int SW  = 20;
    localparam int GAP = 10;
    localparam int BASE = 10;

    // [19:17] sync hold cycles, [16] parity, [15:0] line mask
    localparam logic [19:0] VEC [4] = '{
        {3'd1, 1'b1, 16'h0000},
        {3'd3, 1'b0, 16'hFFFF},
        {3'd1, 1'b0, 16'h0801},
        {3'd2, 1'b1, 16'hA5C3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hs_in = 1'b0, vsync_in = 1'b0, field_par_in = 1'b0, sel_wr = 1'b0;
    logic [15:0] sel_data = '0;
    logic ln26_out, field_odd_out, slice_out;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbi_line_timer #(.LN26_WIDTH(W26), .SLICE_WIDTH(SW), .MIN_HS_GAP(GAP),
                     .SEL_BASE(BASE), .LN26_LINE(26)) dut (
        .clk(clk), .rst(rst), .hs_in(hs_in), .vsync_in(vsync_in),
        .field_par_in(field_par_in), .sel_wr(sel_wr), .sel_data(sel_data),
        .ln26_out(ln26_out), .field_odd_out(field_odd_out), .slice_out(slice_out));

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load_mask(logic [15:0] m);
        sel_wr = 1'b1; sel_data = m;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic field_start(logic par);
        vsync_in = 1'b1; field_par_in = par;
        @(negedge clk);
        vsync_in = 1'b0; field_par_in = ~par;
        repeat (3) @(negedge clk);
    endtask

    task automatic hs_line(int hold, int period, output int n26, output int nsl);
        n26 = 0; nsl = 0;
        hs_in = 1'b1;
        for (int k = 0; k < period; k++) begin
            @(negedge clk);
            n26 += int'(ln26_out);
            nsl += int'(slice_out);
            if (k == hold - 1) hs_in = 1'b0;
        end
        hs_in = 1'b0;
    endtask

    function automatic int exp_slice(int l, logic [15:0] m);
        if (l >= BASE && l < BASE + 16 && m[l-BASE]) return SW;
        return 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int a, b;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ln26 after reset", int'(ln26_out), 0);
        check("R1 slice after reset", int'(slice_out), 0);
        check("R1 field after reset", int'(field_odd_out), 0);

        // R1: sync with no field strobe yet stays quiet
        load_mask(16'hFFFF);
        begin
            int t26 = 0, tsl = 0;
            for (int l = 0; l < 30; l++) begin
                hs_line(1, P, a, b);
                t26 += a; tsl += b;
            end
            check("R1 idle ln26", t26, 0);
            check("R1 idle slice", tsl, 0);
        end

        // table walk: R2 R3 R5 R6 R7
        for (int v = 0; v < 4; v++) begin
            logic [15:0] m = VEC[v][15:0];
            logic par = VEC[v][16];
            int hold = int'(VEC[v][19:17]);
            load_mask(m);
            field_start(par);
            check("R2 field parity", int'(field_odd_out), int'(par));
            for (int l = 2; l <= 30; l++) begin
                hs_line(hold, P, a, b);
                check("R5 ln26 width", a, (l == 26) ? W26 : 0);
                check("R6/R7 slice width", b, exp_slice(l, m));
            end
            check("R2 field held", int'(field_odd_out), int'(par));
        end

        // R4: equalising pulse between line 11 and line 12 is ignored
        load_mask(16'h0004);
        field_start(1'b0);
        for (int l = 2; l <= 10; l++) hs_line(1, P, a, b);
        hs_line(1, 5, a, b);
        check("R4 line 11 quiet", b, 0);
        hs_line(1, P, a, b);
        check("R4 short edge rejected", b, 0);
        hs_line(1, P, a, b);
        check("R4 line 12 gated", b, SW);
        hs_line(1, P, a, b);
        check("R4 line 13 quiet", b, 0);

        // R8: close sync cuts pulse; restarts on enabled line
        load_mask(16'h0034);
        field_start(1'b1);
        for (int l = 2; l <= 11; l++) hs_line(1, P, a, b);
        hs_line(1, 15, a, b);
        check("R8 line 12 cut short", b, 15);
        hs_line(1, P, a, b);
        check("R8 line 13 disabled", b, 0);
        hs_line(1, 15, a, b);
        check("R8 line 14 cut short", b, 15);
        hs_line(1, P, a, b);
        check("R8 line 15 restarted", b, SW);

        // R8: field strobe ends running pulse
        load_mask(16'h0001);
        field_start(1'b0);
        for (int l = 2; l <= 9; l++) hs_line(1, P, a, b);
        hs_in = 1'b1;
        @(negedge clk); hs_in = 1'b0;
        repeat (3) @(negedge clk);
        vsync_in = 1'b1;
        @(negedge clk); vsync_in = 1'b0;
        @(negedge clk);
        check("R8 strobe clears slice", int'(slice_out), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule